// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block gathers the interrupt conditions of a UART channel, holds the ones that are events until the host services them, and gates every source with the interrupt enable register. Of all enabled pending sources, only the most urgent one is shown to the host. It is shown as an 8-bit status code, and a single interrupt line is raised while anything enabled is pending. A lower-priority source becomes visible only after everything above it has been cleared.

The event inputs are single-cycle pulses from the receiver, the transmitter and the modem logic. The receive-data condition is a level that follows the receive FIFO's trigger state. The read and write strobes are single-cycle pulses from the host register decode. They clear the matching pending source on the same clock edge.

Top module: `uart_irq_identifier`

## Requirements
- R1: Enable bit 0 gates both receive data and receive timeout, bit 1 gates transmit empty, bit 2 gates line status error and bit 3 gates modem change; a disabled source never shows in the status code or on the interrupt line.
- R2: The status code is 0x06 for line status, 0x0C for receive timeout, 0x04 for receive data, 0x02 for transmit empty, 0x00 for modem change, and 0x01 when nothing enabled is pending (bit 0 set means no interrupt).
- R3: Only the highest-priority enabled pending source is reported: line status, then the receive level, then transmit empty, then modem change.
- R4: Receive timeout and receive data share one priority level; when both are pending and enabled the timeout code 0x0C is reported.
- R5: A line error pulse latches the line status source, and a line status read clears it on the same edge.
- R6: The receive data source follows the rxReady level with no latching; a receive timeout pulse latches the timeout source, and a receive data read clears it.
- R7: The transmit-empty source is pending right after reset and is set again by a transmit-empty pulse. It clears on a transmit holding write, or on a status read in a cycle where 0x02 is the reported code. A status read in any other cycle leaves it pending.
- R8: A modem change pulse latches the modem source, and a modem status read clears it.
- R9: irqOut is high exactly when some enabled source is pending, which is exactly when bit 0 of the status code is 0.
- R10: When a source's set pulse and its clear strobe arrive in the same cycle, the source ends up pending.
- R11: Sources latch while disabled and appear as soon as their enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intEnable | input | 4 | Interrupt enable bits (see R1) |
| lineErrEvt | input | 1 | Pulse: receive line error detected |
| rxReady | input | 1 | Level: receive FIFO at or above its trigger |
| rxTimeoutEvt | input | 1 | Pulse: receive character timeout |
| txEmptyEvt | input | 1 | Pulse: transmit holding register became empty |
| modemChgEvt | input | 1 | Pulse: modem or flow-control input changed |
| lineStatusRd | input | 1 | Pulse: host read of line status |
| rxDataRd | input | 1 | Pulse: host read of receive data |
| statusRd | input | 1 | Pulse: host read of the interrupt status code |
| txHoldWr | input | 1 | Pulse: host write of transmit holding data |
| modemStatusRd | input | 1 | Pulse: host read of modem status |
| statusCode | output | 8 | Code of the highest-priority enabled pending source |
| irqOut | output | 1 | Interrupt request line |

## Verification
The checker keeps several relations true on every cycle. The interrupt line is always the inverse of code bit 0, and the code is always a legal value. A disabled line-status source never appears. A line error always shows one cycle later when it is enabled, with or without a clashing read. A transmit write always hides the transmit code, and the data code implies the data level is present. The priority masking and the unmasking of lower sources after service can only be shown by bench scenarios that stack several sources and then clear them one at a time. The same holds for the clear-on-status-read rule that depends on which code was reported, and for latching while disabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int CODE_W  = 8;
  localparam int EN_W    = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);

  // Source indices, lowest index = highest priority
  localparam int SRC_LINE = 0;
  localparam int SRC_TMO  = 1;
  localparam int SRC_RXD  = 2;
  localparam int SRC_TX   = 3;
  localparam int SRC_MDM  = 4;

  localparam logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'(1) << SRC_RXD;
  localparam logic [NUM_SRC-1:0] RESET_PEND = NUM_SRC'(1) << SRC_TX;

  localparam logic [CODE_W-1:0] CODE_IDLE = 8'h01;

  typedef struct packed {
    logic [NUM_SRC-1:0] clear;
  } irq_strobe_t;

  function automatic logic [CODE_W-1:0] srcCode(input int idx);
    case (idx)
      SRC_LINE: srcCode = 8'h06;
      SRC_TMO:  srcCode = 8'h0C;
      SRC_RXD:  srcCode = 8'h04;
      SRC_TX:   srcCode = 8'h02;
      default:  srcCode = 8'h00;
    endcase
  endfunction

  function automatic int srcEnBit(input int idx);
    case (idx)
      SRC_LINE: srcEnBit = 2;
      SRC_TMO:  srcEnBit = 0;
      SRC_RXD:  srcEnBit = 0;
      SRC_TX:   srcEnBit = 1;
      default:  srcEnBit = 3;
    endcase
  endfunction
endpackage

// File: rtl/irq_pend_datapath.sv
module irq_pend_datapath
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter logic [N-1:0] LEVEL = LEVEL_MASK,
  parameter logic [N-1:0] RST_VAL = RESET_PEND
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [N-1:0] srcIn,
  input  irq_strobe_t strobe,
  output logic [N-1:0] pending
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_src
      if (LEVEL[gi]) begin : g_level
        assign pending[gi] = srcIn[gi];
      end else begin : g_latch
        logic pendQ;
        always_ff @(posedge clk) begin
          if (!rstN)
            pendQ <= RST_VAL[gi];
          else if (srcIn[gi])
            pendQ <= 1'b1;          // set has priority over clear
          else if (strobe.clear[gi])
            pendQ <= 1'b0;
        end
        assign pending[gi] = pendQ;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]      pending,
  input  logic [EN_W-1:0]   intEnable,
  input  logic              lineStatusRd,
  input  logic              rxDataRd,
  input  logic              statusRd,
  input  logic              txHoldWr,
  input  logic              modemStatusRd,
  output irq_strobe_t       strobe,
  output logic [CODE_W-1:0] statusCode,
  output logic              irqOut
);
  logic [N-1:0] active;
  logic [SEL_W-1:0] selIdx;
  logic anyActive;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_mask
      assign active[gi] = pending[gi] & intEnable[srcEnBit(gi)];
    end
  endgenerate

  // Fixed-priority pick: lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (active[i]) selIdx = SEL_W'(i);
    end
  end

  assign anyActive  = |active;
  assign irqOut     = anyActive;
  assign statusCode = anyActive ? srcCode(int'(selIdx)) : CODE_IDLE;

  always_comb begin
    strobe = '0;
    strobe.clear[SRC_LINE] = lineStatusRd;
    strobe.clear[SRC_TMO]  = rxDataRd;
    strobe.clear[SRC_TX]   = txHoldWr |
                             (statusRd & anyActive & (selIdx == SEL_W'(SRC_TX)));
    strobe.clear[SRC_MDM]  = modemStatusRd;
  end
endmodule

// File: rtl/uart_irq_identifier.sv
module uart_irq_identifier
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [EN_W-1:0]   intEnable,
  input  logic              lineErrEvt,
  input  logic              rxReady,
  input  logic              rxTimeoutEvt,
  input  logic              txEmptyEvt,
  input  logic              modemChgEvt,
  input  logic              lineStatusRd,
  input  logic              rxDataRd,
  input  logic              statusRd,
  input  logic              txHoldWr,
  input  logic              modemStatusRd,
  output logic [CODE_W-1:0] statusCode,
  output logic              irqOut
);
  logic [NUM_SRC-1:0] srcIn;
  logic [NUM_SRC-1:0] pending;
  irq_strobe_t strobe;

  always_comb begin
    srcIn = '0;
    srcIn[SRC_LINE] = lineErrEvt;
    srcIn[SRC_TMO]  = rxTimeoutEvt;
    srcIn[SRC_RXD]  = rxReady;
    srcIn[SRC_TX]   = txEmptyEvt;
    srcIn[SRC_MDM]  = modemChgEvt;
  end

  irq_pend_datapath #(.N(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strobe(strobe), .pending(pending)
  );

  irq_prio_control #(.N(NUM_SRC)) u_ctl (
    .pending(pending), .intEnable(intEnable),
    .lineStatusRd(lineStatusRd), .rxDataRd(rxDataRd), .statusRd(statusRd),
    .txHoldWr(txHoldWr), .modemStatusRd(modemStatusRd),
    .strobe(strobe), .statusCode(statusCode), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_checker.sv
module irq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] intEnable,
  input logic       lineErrEvt,
  input logic       rxReady,
  input logic       txEmptyEvt,
  input logic       txHoldWr,
  input logic [7:0] statusCode,
  input logic       irqOut
);
  assert_irq_matches_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == !statusCode[0]);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusCode inside {8'h06, 8'h0C, 8'h04, 8'h02, 8'h00, 8'h01});

  assert_line_masked_R1: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable[2] |-> statusCode != 8'h06);

  assert_line_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lineErrEvt && intEnable[2]) |=> (intEnable[2] -> statusCode == 8'h06));

  assert_tx_write_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txHoldWr && !txEmptyEvt) |=> statusCode != 8'h02);

  assert_data_needs_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusCode == 8'h04 |-> (rxReady && intEnable[0]));
endmodule

bind uart_irq_identifier irq_checker u_chk (
  .clk(clk), .rstN(rstN), .intEnable(intEnable), .lineErrEvt(lineErrEvt),
  .rxReady(rxReady), .txEmptyEvt(txEmptyEvt), .txHoldWr(txHoldWr),
  .statusCode(statusCode), .irqOut(irqOut)
);

// File: tb/uart_irq_identifier_tb.sv
`timescale 1ns/1ps
module uart_irq_identifier_tb;
  logic clk = 0, rstN = 0;
  logic [3:0] intEnable = 0;
  logic lineErrEvt = 0, rxReady = 0, rxTimeoutEvt = 0, txEmptyEvt = 0, modemChgEvt = 0;
  logic lineStatusRd = 0, rxDataRd = 0, statusRd = 0, txHoldWr = 0, modemStatusRd = 0;
  logic [7:0] statusCode;
  logic irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  // model pending state
  bit mLine, mTmo, mTx, mMdm;

  always #2 clk = ~clk;

  uart_irq_identifier u_dut (.*);

  function automatic logic [7:0] expCode();
    if (mLine && intEnable[2]) return 8'h06;
    if (mTmo && intEnable[0]) return 8'h0C;
    if (rxReady && intEnable[0]) return 8'h04;
    if (mTx && intEnable[1]) return 8'h02;
    if (mMdm && intEnable[3]) return 8'h00;
    return 8'h01;
  endfunction

  function automatic string tagOf(input logic [7:0] c);
    case (c)
      8'h06: return "R5";
      8'h0C: return "R4";
      8'h04: return "R6";
      8'h02: return "R7";
      8'h00: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    lineErrEvt = 0; rxTimeoutEvt = 0; txEmptyEvt = 0; modemChgEvt = 0;
    lineStatusRd = 0; rxDataRd = 0; statusRd = 0; txHoldWr = 0; modemStatusRd = 0;
  endtask

  // inputs already driven; clock one edge, update model, compare
  task automatic step();
    logic [7:0] pre, e;
    pre = expCode();
    @(posedge clk);
    if (lineErrEvt) mLine = 1; else if (lineStatusRd) mLine = 0;
    if (rxTimeoutEvt) mTmo = 1; else if (rxDataRd) mTmo = 0;
    if (txEmptyEvt) mTx = 1; else if (txHoldWr || (statusRd && pre == 8'h02)) mTx = 0;
    if (modemChgEvt) mMdm = 1; else if (modemStatusRd) mMdm = 0;
    #1;
    clearIns();
    #0.5;
    e = expCode();
    check(tagOf(e), statusCode, e);
    check("R9", {7'b0, irqOut}, {7'b0, !e[0]});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    mLine = 0; mTmo = 0; mTx = 1; mMdm = 0;
    #0.5;
    check("R1", statusCode, 8'h01);          // reset, nothing enabled
    check("R9", {7'b0, irqOut}, 8'h00);
    // R7: transmit empty after reset once enabled
    intEnable = 4'b0010; #0.5;
    check("R7", statusCode, 8'h02);
    // R7: status read while not reported keeps tx pending
    intEnable = 4'b0110; lineErrEvt = 1; step();
    check("R3", statusCode, 8'h06);
    statusRd = 1; step();
    lineStatusRd = 1; step();
    check("R7", statusCode, 8'h02);
    statusRd = 1; step();
    check("R7", statusCode, 8'h01);
    // stack all sources
    intEnable = 4'b1111;
    lineErrEvt = 1; rxTimeoutEvt = 1; modemChgEvt = 1; txEmptyEvt = 1; rxReady = 1; step();
    check("R2", statusCode, 8'h06);
    lineStatusRd = 1; step();
    check("R4", statusCode, 8'h0C);
    rxDataRd = 1; step();
    check("R6", statusCode, 8'h04);
    rxReady = 0; step();
    check("R3", statusCode, 8'h02);
    txHoldWr = 1; step();
    check("R8", statusCode, 8'h00);
    // R11: masked while disabled, visible on re-enable
    intEnable = 4'b0111; step();
    check("R11", statusCode, 8'h01);
    intEnable = 4'b1111; step();
    check("R11", statusCode, 8'h00);
    modemStatusRd = 1; step();
    check("R8", statusCode, 8'h01);
    // R10: set and clear together leaves pending
    lineErrEvt = 1; lineStatusRd = 1; step();
    check("R10", statusCode, 8'h06);
    lineStatusRd = 1; step();
    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) intEnable = 4'($urandom);
      if ($urandom_range(0, 7) == 0) rxReady = ~rxReady;
      lineErrEvt    = ($urandom_range(0, 9) == 0);
      rxTimeoutEvt  = ($urandom_range(0, 9) == 0);
      txEmptyEvt    = ($urandom_range(0, 9) == 0);
      modemChgEvt   = ($urandom_range(0, 9) == 0);
      lineStatusRd  = ($urandom_range(0, 5) == 0);
      rxDataRd      = ($urandom_range(0, 5) == 0);
      statusRd      = ($urandom_range(0, 3) == 0);
      txHoldWr      = ($urandom_range(0, 7) == 0);
      modemStatusRd = ($urandom_range(0, 5) == 0);
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule